// File: doc/BRIEF.md
# Debug Abstract Command Controller

This block is the abstract-command front end of a debug module. A debugger reaches it through a simple register port: one request cycle carries an address, a write enable and write data, and read data comes back in the same cycle. Behind that port sit the following registers:

- two data registers;
- a control/status word;
- a command register;
- an autoexec register.

When a command is written, the block checks that it is legal. It also checks that the hart is halted. If both checks pass, it raises a request on a backend port and holds that request until the backend answers with a done pulse and an error class.

The block records problems as a sticky error code. While that code is nonzero, no new command starts. Touching any of the five registers while a command is in flight is itself recorded as a busy error. When autoexec is enabled, accesses to the data registers re-issue the stored command without a new command write, so a debugger can stream a block of words.

After a successful command, post-increment advances either the register number or the memory address. The register file and memory fabric themselves live outside the block.

Top module: `abscmd_ctrl`

## Requirements
- R1: After reset the data registers, autoexec and error code are zero, no request is pending, and the control/status word reads 0x00000002.
- R2: Register map: data0 at 0x04 and data1 at 0x05 are read/write; autoexec at 0x18 holds bits 1:0. The control/status word at 0x16 shows busy in bit 12, the error code in bits 10:8 and the data count 2 in bits 3:0. The command register at 0x17 reads as zero.
- R3: Command word layout:
  - bits 31:24: type (0 = register, 2 = memory);
  - bits 22:20: size;
  - bit 19: post-increment;
  - bit 18: postexec;
  - bit 16: write;
  - bits 15:0: register number.

  A legal command written while idle, with error code 0 and the hart halted, raises be_req on the next cycle. be_req stays high until be_done.
- R4: On be_done with error class 0, be_req drops on the following cycle. For a read command, be_rdata is stored into data0.
- R5: Each of the following stores error code 2 and issues no request:
  - a type other than 0 or 2;
  - a register command with size other than 2;
  - a register command with postexec set;
  - a register command with register number at or above REGNO_LIMIT (default 0x1020);
  - a memory command with size above 2.
- R6: A legal command requested while hart_halted is low stores error code 4 and issues no request.
- R7: Backend error class 1 stores error code 3; class 2 or 3 stores error code 5.
- R8: Any access to the five registers while busy sets the error code to 1 when it was 0. Writes made while busy change no register.
- R9: While the error code is nonzero, command writes start nothing. Writing ones to bits 10:8 of the control/status word clears exactly those error bits.
- R10: With autoexec bit 0 (bit 1) set, any read or write of data0 (data1) re-issues the stored command. An access to the other data register does not.
- R11: When post-increment is set and the command succeeds, the register number grows by 1 (register type) or data1 grows by 2^size (memory type). A failed command leaves both unchanged.
- R12: A memory command drives be_mem high, be_addr from data1, be_wdata from data0, and be_size and be_write from the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dmi_req | input | 1 | Register access strobe |
| dmi_we | input | 1 | 1 = write, 0 = read |
| dmi_addr | input | 7 | Register address |
| dmi_wdata | input | 32 | Write data |
| dmi_rdata | output | 32 | Read data for the addressed register |
| hart_halted | input | 1 | Hart is halted |
| be_req | output | 1 | Backend operation pending |
| be_mem | output | 1 | 1 = memory access, 0 = register access |
| be_write | output | 1 | Operation writes |
| be_size | output | 3 | Access size code |
| be_regno | output | 16 | Register number |
| be_addr | output | 32 | Memory address |
| be_wdata | output | 32 | Write data |
| be_done | input | 1 | Backend completion pulse |
| be_err | input | 2 | Completion error class |
| be_rdata | input | 32 | Read result |

## Verification
Commands are driven through the register port in several forms: legal register and memory reads and writes, and each illegal field pattern. Each illegal pattern must map to code 2 rather than to a halt or backend code, so these cases show whether the legality checks run before the halted test.

Further runs cover the following:
- a halted and a running hart;
- backend error classes 1 and 2, which tell the two fault codes apart and show that post-increment is suppressed on failure;
- a data write placed one cycle after a command write, which must raise the busy error without landing in data0;
- autoexec with each bit alone, which shows that only the selected data register re-issues.

// File: rtl/abscmd_pkg.sv
package abscmd_pkg;

   localparam int unsigned ADDR_W = 7;

   localparam logic [ADDR_W-1:0] ADR_DATA0 = 7'h04;
   localparam logic [ADDR_W-1:0] ADR_DATA1 = 7'h05;
   localparam logic [ADDR_W-1:0] ADR_CTRL  = 7'h16;
   localparam logic [ADDR_W-1:0] ADR_CMD   = 7'h17;
   localparam logic [ADDR_W-1:0] ADR_AUTO  = 7'h18;

   localparam logic [3:0] DATA_COUNT = 4'd2;

   localparam logic [2:0] ERR_NONE = 3'd0;
   localparam logic [2:0] ERR_BUSY = 3'd1;
   localparam logic [2:0] ERR_UNSUP = 3'd2;
   localparam logic [2:0] ERR_EXC = 3'd3;
   localparam logic [2:0] ERR_HALT = 3'd4;
   localparam logic [2:0] ERR_BUS = 3'd5;

   localparam logic [7:0] TYPE_REG = 8'd0;
   localparam logic [7:0] TYPE_MEM = 8'd2;

   typedef struct packed {
      logic [7:0]  cmdtype;
      logic        rsvd;
      logic [2:0]  size;
      logic        postinc;
      logic        postexec;
      logic        transfer;
      logic        write;
      logic [15:0] regno;
   } cmd_t;

endpackage

// File: rtl/abscmd_check.sv
module abscmd_check #(
   parameter int unsigned REGNO_LIMIT   = 32'h1020,
   parameter bit          MEM_ACCESS_EN = 1'b1
) (
   input  abscmd_pkg::cmd_t cmd,
   input  logic             hart_halted,
   output logic [2:0]       err
);
   import abscmd_pkg::*;

   logic reg_ok;
   logic mem_ok;

   assign reg_ok = (cmd.cmdtype == TYPE_REG) && (cmd.size == 3'd2) &&
                   !cmd.postexec && (32'(cmd.regno) < REGNO_LIMIT);

   generate
      if (MEM_ACCESS_EN) begin : g_mem
         assign mem_ok = (cmd.cmdtype == TYPE_MEM) && (cmd.size <= 3'd2);
      end else begin : g_nomem
         assign mem_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!(reg_ok || mem_ok))
         err = ERR_UNSUP;
      else if (!hart_halted)
         err = ERR_HALT;
      else
         err = ERR_NONE;
   end

   logic unused_fields;
   assign unused_fields = ^{cmd.rsvd, cmd.transfer, cmd.write, cmd.postinc};

endmodule

// File: rtl/abscmd_tracker.sv
module abscmd_tracker (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       launch_try,
   input  logic [2:0] chk_err,
   input  logic       busy_touch,
   input  logic       ctrl_wr,
   input  logic [2:0] clr_mask,
   input  logic       be_done,
   input  logic [1:0] be_err,
   output logic       busy,
   output logic [2:0] cmderr,
   output logic       done_ok
);
   import abscmd_pkg::*;

   logic [2:0] be_code;
   logic       finish;

   assign finish  = busy && be_done;
   assign done_ok = finish && (be_err == 2'd0);
   assign be_code = (be_err == 2'd1) ? ERR_EXC : ERR_BUS;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cmderr <= ERR_NONE;
      end else begin
         if (finish)
            busy <= 1'b0;
         else if (launch_try && chk_err == ERR_NONE)
            busy <= 1'b1;

         if (finish && be_err != 2'd0 && cmderr == ERR_NONE)
            cmderr <= be_code;
         else if (busy_touch && cmderr == ERR_NONE)
            cmderr <= ERR_BUSY;
         else if (launch_try && chk_err != ERR_NONE)
            cmderr <= chk_err;
         else if (ctrl_wr && !busy)
            cmderr <= cmderr & ~clr_mask;
      end
   end

endmodule

// File: rtl/abscmd_ctrl.sv
module abscmd_ctrl #(
   parameter int unsigned REGNO_LIMIT   = 32'h1020,
   parameter bit          MEM_ACCESS_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        dmi_req,
   input  logic        dmi_we,
   input  logic [6:0]  dmi_addr,
   input  logic [31:0] dmi_wdata,
   output logic [31:0] dmi_rdata,
   input  logic        hart_halted,
   output logic        be_req,
   output logic        be_mem,
   output logic        be_write,
   output logic [2:0]  be_size,
   output logic [15:0] be_regno,
   output logic [31:0] be_addr,
   output logic [31:0] be_wdata,
   input  logic        be_done,
   input  logic [1:0]  be_err,
   input  logic [31:0] be_rdata
);
   import abscmd_pkg::*;

   generate
      if (REGNO_LIMIT < 1 || REGNO_LIMIT > 65536) begin : g_bad_limit
         $error("abscmd_ctrl: REGNO_LIMIT must lie in 1..65536");
      end
   endgenerate

   logic [31:0] data0_q;
   logic [31:0] data1_q;
   cmd_t        cmd_q;
   logic [1:0]  auto_q;

   logic       busy;
   logic [2:0] cmderr_q;
   logic       done_ok;

   logic hit_d0, hit_d1, hit_ctrl, hit_cmd, hit_auto, hit_any;
   logic idle_wr;
   logic launch_try;
   logic busy_touch;
   cmd_t chk_cmd;
   logic [2:0] chk_err;

   assign hit_d0   = dmi_req && (dmi_addr == ADR_DATA0);
   assign hit_d1   = dmi_req && (dmi_addr == ADR_DATA1);
   assign hit_ctrl = dmi_req && (dmi_addr == ADR_CTRL);
   assign hit_cmd  = dmi_req && (dmi_addr == ADR_CMD);
   assign hit_auto = dmi_req && (dmi_addr == ADR_AUTO);
   assign hit_any  = hit_d0 || hit_d1 || hit_ctrl || hit_cmd || hit_auto;

   assign idle_wr    = dmi_we && !busy;
   assign busy_touch = busy && hit_any;
   assign launch_try = !busy && (cmderr_q == ERR_NONE) &&
                       ((hit_cmd && dmi_we) ||
                        (hit_d0 && auto_q[0]) ||
                        (hit_d1 && auto_q[1]));
   assign chk_cmd    = (hit_cmd && dmi_we) ? cmd_t'(dmi_wdata) : cmd_q;

   abscmd_check #(
      .REGNO_LIMIT  (REGNO_LIMIT),
      .MEM_ACCESS_EN(MEM_ACCESS_EN)
   ) u_check (
      .cmd        (chk_cmd),
      .hart_halted(hart_halted),
      .err        (chk_err)
   );

   abscmd_tracker u_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch_try(launch_try),
      .chk_err   (chk_err),
      .busy_touch(busy_touch),
      .ctrl_wr   (hit_ctrl && dmi_we),
      .clr_mask  (dmi_wdata[10:8]),
      .be_done   (be_done),
      .be_err    (be_err),
      .busy      (busy),
      .cmderr    (cmderr_q),
      .done_ok   (done_ok)
   );

   logic run_mem;
   assign run_mem = (cmd_q.cmdtype == TYPE_MEM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data0_q <= '0;
         data1_q <= '0;
         cmd_q   <= '0;
         auto_q  <= '0;
      end else begin
         if (hit_d0 && idle_wr)
            data0_q <= dmi_wdata;
         else if (done_ok && !cmd_q.write)
            data0_q <= be_rdata;

         if (hit_d1 && idle_wr)
            data1_q <= dmi_wdata;
         else if (done_ok && run_mem && cmd_q.postinc)
            data1_q <= data1_q + (32'd1 << cmd_q.size);

         if (hit_cmd && idle_wr && cmderr_q == ERR_NONE)
            cmd_q <= cmd_t'(dmi_wdata);
         else if (done_ok && !run_mem && cmd_q.postinc)
            cmd_q.regno <= cmd_q.regno + 16'd1;

         if (hit_auto && idle_wr)
            auto_q <= dmi_wdata[1:0];
      end
   end

   always_comb begin
      case (dmi_addr)
         ADR_DATA0: dmi_rdata = data0_q;
         ADR_DATA1: dmi_rdata = data1_q;
         ADR_CTRL:  dmi_rdata = {19'd0, busy, 1'b0, cmderr_q, 4'd0, DATA_COUNT};
         ADR_AUTO:  dmi_rdata = {30'd0, auto_q};
         default:   dmi_rdata = 32'd0;
      endcase
   end

   assign be_req   = busy;
   assign be_mem   = run_mem;
   assign be_write = cmd_q.write;
   assign be_size  = cmd_q.size;
   assign be_regno = cmd_q.regno;
   assign be_addr  = data1_q;
   assign be_wdata = data0_q;

endmodule

// File: rtl/abscmd_ctrl_chk.sv
module abscmd_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        dmi_req,
   input logic        dmi_we,
   input logic [6:0]  dmi_addr,
   input logic        hart_halted,
   input logic        be_req,
   input logic        be_done,
   input logic [2:0]  cmderr,
   input logic [31:0] data0
);
   import abscmd_pkg::*;

   assert_hold_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (be_req && !be_done) |=> be_req);

   assert_drop_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (be_req && be_done) |=> !be_req);

   assert_start_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(be_req) |-> ($past(cmderr) == ERR_NONE));

   assert_start_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(be_req) |-> $past(hart_halted));

   assert_sticky_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmderr != ERR_NONE && !(dmi_req && dmi_we && dmi_addr == ADR_CTRL))
      |=> $stable(cmderr));

   assert_busy_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (be_req && !be_done && dmi_req && dmi_we && dmi_addr == ADR_DATA0)
      |=> $stable(data0));

endmodule

bind abscmd_ctrl abscmd_ctrl_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dmi_req    (dmi_req),
   .dmi_we     (dmi_we),
   .dmi_addr   (dmi_addr),
   .hart_halted(hart_halted),
   .be_req     (be_req),
   .be_done    (be_done),
   .cmderr     (cmderr_q),
   .data0      (data0_q)
);

// File: tb/test_abscmd_ctrl.sv
`timescale 1ns/1ps
module test_abscmd_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dmi_req = 1'b0;
   logic        dmi_we = 1'b0;
   logic [6:0]  dmi_addr = '0;
   logic [31:0] dmi_wdata = '0;
   logic [31:0] dmi_rdata;
   logic        hart_halted = 1'b1;
   logic        be_req, be_mem, be_write;
   logic [2:0]  be_size;
   logic [15:0] be_regno;
   logic [31:0] be_addr, be_wdata;
   logic        be_done = 1'b0;
   logic [1:0]  be_err = 2'd0;
   logic [31:0] be_rdata = 32'hCAFE0001;

   always #4 clk = ~clk;

   abscmd_ctrl i_abscmd_ctrl (
      .clk(clk), .rst_n(rst_n), .dmi_req(dmi_req), .dmi_we(dmi_we),
      .dmi_addr(dmi_addr), .dmi_wdata(dmi_wdata), .dmi_rdata(dmi_rdata),
      .hart_halted(hart_halted), .be_req(be_req), .be_mem(be_mem),
      .be_write(be_write), .be_size(be_size), .be_regno(be_regno),
      .be_addr(be_addr), .be_wdata(be_wdata), .be_done(be_done),
      .be_err(be_err), .be_rdata(be_rdata)
   );

   int n_chk = 0;
   int n_fail = 0;
   int req_cnt = 0;
   int lat = 0;
   logic        cap_mem, cap_write;
   logic [2:0]  cap_size;
   logic [15:0] cap_regno;
   logic [31:0] cap_addr, cap_wdata;

   // backend model: answers two cycles after seeing a request
   always @(negedge clk) begin
      if (!rst_n) begin
         be_done <= 1'b0;
         lat <= 0;
      end else if (be_done) begin
         be_done <= 1'b0;
         lat <= 0;
      end else if (be_req) begin
         if (lat == 2) begin
            be_done   <= 1'b1;
            req_cnt   <= req_cnt + 1;
            cap_mem   <= be_mem;
            cap_write <= be_write;
            cap_size  <= be_size;
            cap_regno <= be_regno;
            cap_addr  <= be_addr;
            cap_wdata <= be_wdata;
         end else begin
            lat <= lat + 1;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   logic [31:0] rd_val;

   // called at a falling edge; returns at the next falling edge
   task automatic dmi_op(input logic we, input logic [6:0] addr, input logic [31:0] wd);
      dmi_req = 1'b1;
      dmi_we = we;
      dmi_addr = addr;
      dmi_wdata = wd;
      #1 rd_val = dmi_rdata;
      @(negedge clk);
      dmi_req = 1'b0;
      dmi_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic rd_chk(input string tag, input logic [6:0] addr, input logic [31:0] exp);
      dmi_op(1'b0, addr, 32'd0);
      check(tag, rd_val, exp);
   endtask

   typedef struct packed {
      logic        we;
      logic [6:0]  addr;
      logic [31:0] wd;
      logic        chk;
      logic [31:0] exp;
      logic [3:0]  gap;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 38;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 7'h16, 32'h0, 1'b1, 32'h00000002, 4'd0, 4'd1},  // R1 reset control word
      '{1'b0, 7'h04, 32'h0, 1'b1, 32'h00000000, 4'd0, 4'd1},  // R1 data0 zero
      '{1'b1, 7'h04, 32'h11111111, 1'b0, 32'h0, 4'd0, 4'd2},  // R2
      '{1'b0, 7'h04, 32'h0, 1'b1, 32'h11111111, 4'd0, 4'd2},  // R2
      '{1'b1, 7'h05, 32'h20000000, 1'b0, 32'h0, 4'd0, 4'd2},  // R2
      '{1'b0, 7'h05, 32'h0, 1'b1, 32'h20000000, 4'd0, 4'd2},  // R2
      '{1'b1, 7'h18, 32'hFFFFFFFF, 1'b0, 32'h0, 4'd0, 4'd2},  // R2 autoexec width
      '{1'b0, 7'h18, 32'h0, 1'b1, 32'h00000003, 4'd0, 4'd2},  // R2
      '{1'b1, 7'h18, 32'h0, 1'b0, 32'h0, 4'd0, 4'd2},         // R2
      '{1'b0, 7'h18, 32'h0, 1'b1, 32'h00000000, 4'd0, 4'd2},  // R2
      '{1'b1, 7'h17, 32'h00221005, 1'b0, 32'h0, 4'd6, 4'd3},  // R3 register read
      '{1'b0, 7'h04, 32'h0, 1'b1, 32'hCAFE0001, 4'd0, 4'd4},  // R4 result stored
      '{1'b0, 7'h16, 32'h0, 1'b1, 32'h00000002, 4'd0, 4'd4},  // R4 busy clear
      '{1'b1, 7'h17, 32'h01220000, 1'b0, 32'h0, 4'd2, 4'd5},  // R5 type 1
      '{1'b0, 7'h16, 32'h0, 1'b1, 32'h00000202, 4'd0, 4'd5},
      '{1'b1, 7'h16, 32'h00000700, 1'b0, 32'h0, 4'd0, 4'd9},  // R9 clear
      '{1'b0, 7'h16, 32'h0, 1'b1, 32'h00000002, 4'd0, 4'd9},
      '{1'b1, 7'h17, 32'h00320000, 1'b0, 32'h0, 4'd2, 4'd5},  // R5 reg size 3
      '{1'b0, 7'h16, 32'h0, 1'b1, 32'h00000202, 4'd0, 4'd5},
      '{1'b1, 7'h16, 32'h00000700, 1'b0, 32'h0, 4'd0, 4'd9},
      '{1'b1, 7'h17, 32'h00260000, 1'b0, 32'h0, 4'd2, 4'd5},  // R5 postexec
      '{1'b0, 7'h16, 32'h0, 1'b1, 32'h00000202, 4'd0, 4'd5},
      '{1'b1, 7'h16, 32'h00000700, 1'b0, 32'h0, 4'd0, 4'd9},
      '{1'b1, 7'h17, 32'h00221020, 1'b0, 32'h0, 4'd2, 4'd5},  // R5 regno at limit
      '{1'b0, 7'h16, 32'h0, 1'b1, 32'h00000202, 4'd0, 4'd5},
      '{1'b1, 7'h16, 32'h00000700, 1'b0, 32'h0, 4'd0, 4'd9},
      '{1'b1, 7'h17, 32'h02310000, 1'b0, 32'h0, 4'd2, 4'd5},  // R5 mem size 3
      '{1'b0, 7'h16, 32'h0, 1'b1, 32'h00000202, 4'd0, 4'd5},
      '{1'b1, 7'h16, 32'h00000700, 1'b0, 32'h0, 4'd0, 4'd9},
      '{1'b1, 7'h17, 32'h02200000, 1'b0, 32'h0, 4'd6, 4'd4},  // R4 memory read
      '{1'b0, 7'h04, 32'h0, 1'b1, 32'hCAFE0001, 4'd0, 4'd4},
      '{1'b0, 7'h17, 32'h0, 1'b1, 32'h00000000, 4'd0, 4'd2},  // R2 command reads 0
      '{1'b1, 7'h17, 32'h03220000, 1'b0, 32'h0, 4'd2, 4'd5},  // R5 type 3
      '{1'b0, 7'h16, 32'h0, 1'b1, 32'h00000202, 4'd0, 4'd5},
      '{1'b1, 7'h16, 32'h00000100, 1'b0, 32'h0, 4'd0, 4'd9},  // R9 partial clear
      '{1'b0, 7'h16, 32'h0, 1'b1, 32'h00000202, 4'd0, 4'd9},
      '{1'b1, 7'h16, 32'h00000200, 1'b0, 32'h0, 4'd0, 4'd9},
      '{1'b0, 7'h16, 32'h0, 1'b1, 32'h00000002, 4'd0, 4'd9}
   };

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int cnt0;
      @(negedge clk);
      idle(2);
      check("R1", 32'(be_req), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         dmi_op(VEC[k].we, VEC[k].addr, VEC[k].wd);
         if (VEC[k].chk)
            check($sformatf("R%0d vector %0d", VEC[k].req, k), rd_val, VEC[k].exp);
         idle(int'(VEC[k].gap));
      end

      // R8: data write one cycle after a command write
      dmi_op(1'b1, 7'h04, 32'hABCD0000);
      dmi_op(1'b1, 7'h05, 32'h00000300);
      dmi_op(1'b1, 7'h17, 32'h02210000);
      check("R3 request raised", 32'(be_req), 32'd1);
      dmi_op(1'b1, 7'h04, 32'h00007777);
      idle(6);
      check("R4 request dropped", 32'(be_req), 32'd0);
      rd_chk("R8 busy code", 7'h16, 32'h00000102);
      rd_chk("R8 data0 kept", 7'h04, 32'hABCD0000);

      // R9: sticky code blocks a legal command
      cnt0 = req_cnt;
      dmi_op(1'b1, 7'h17, 32'h00221005);
      idle(6);
      check("R9 no request", req_cnt, cnt0);
      rd_chk("R9 code kept", 7'h16, 32'h00000102);
      dmi_op(1'b1, 7'h16, 32'h00000700);

      // R6: hart running
      hart_halted = 1'b0;
      cnt0 = req_cnt;
      dmi_op(1'b1, 7'h17, 32'h00221005);
      idle(6);
      check("R6 no request", req_cnt, cnt0);
      rd_chk("R6 halt code", 7'h16, 32'h00000402);
      dmi_op(1'b1, 7'h16, 32'h00000700);
      hart_halted = 1'b1;

      // R7: backend error classes, post-increment suppressed
      be_err = 2'd1;
      dmi_op(1'b1, 7'h05, 32'h00000040);
      dmi_op(1'b1, 7'h17, 32'h02280000);
      idle(6);
      rd_chk("R7 class 1", 7'h16, 32'h00000302);
      rd_chk("R11 no increment on failure", 7'h05, 32'h00000040);
      dmi_op(1'b1, 7'h16, 32'h00000700);
      be_err = 2'd2;
      dmi_op(1'b1, 7'h17, 32'h02280000);
      idle(6);
      rd_chk("R7 class 2", 7'h16, 32'h00000502);
      dmi_op(1'b1, 7'h16, 32'h00000700);
      be_err = 2'd0;

      // R12 / R11: memory write with post-increment
      dmi_op(1'b1, 7'h04, 32'h5555AAAA);
      dmi_op(1'b1, 7'h05, 32'h00001000);
      dmi_op(1'b1, 7'h17, 32'h02290000);
      idle(6);
      check("R12 mem flag", 32'(cap_mem), 32'd1);
      check("R12 write flag", 32'(cap_write), 32'd1);
      check("R12 address", cap_addr, 32'h00001000);
      check("R12 data", cap_wdata, 32'h5555AAAA);
      check("R12 size", 32'(cap_size), 32'd2);
      rd_chk("R11 word step", 7'h05, 32'h00001004);
      dmi_op(1'b1, 7'h17, 32'h02090000);
      idle(6);
      rd_chk("R11 byte step", 7'h05, 32'h00001005);

      // R10 / R11: register post-increment and autoexec
      dmi_op(1'b1, 7'h17, 32'h00281005);
      idle(6);
      check("R11 first regno", 32'(cap_regno), 32'h1005);
      check("R12 register type", 32'(cap_mem), 32'd0);
      dmi_op(1'b1, 7'h18, 32'h00000001);
      cnt0 = req_cnt;
      dmi_op(1'b0, 7'h04, 32'd0);
      idle(6);
      check("R10 data0 reissue", req_cnt, cnt0 + 1);
      check("R11 regno stepped", 32'(cap_regno), 32'h1006);
      dmi_op(1'b1, 7'h18, 32'h00000002);
      cnt0 = req_cnt;
      dmi_op(1'b0, 7'h04, 32'd0);
      idle(6);
      check("R10 data0 not armed", req_cnt, cnt0);
      dmi_op(1'b1, 7'h05, 32'h00000000);
      idle(6);
      check("R10 data1 reissue", req_cnt, cnt0 + 1);
      check("R11 regno stepped again", 32'(cap_regno), 32'h1007);

      // R1: reset in mid-run
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk("R1 data0 after reset", 7'h04, 32'h0);
      rd_chk("R1 data1 after reset", 7'h05, 32'h0);
      rd_chk("R1 autoexec after reset", 7'h18, 32'h0);
      rd_chk("R1 control after reset", 7'h16, 32'h00000002);

      finish_run();
   end

endmodule